// File: doc/BRIEF.md
# Two-Stage Bit-Rate Timing Generator

This block turns the chip input clock into the timing pulses used by the serial port. It works in two cascaded stages inside a single clock domain. A short programmable prescaler divides the input clock and emits a one-cycle system enable. That enable is the time base that the rest of the chip uses as its internal system clock. A wider programmable divider then counts system enables and emits a one-cycle baud tick, which drives the serial transmitter and receiver.

Neither stage produces a derived clock. Both produce enable pulses that are one input-clock cycle wide. With a prescale setting N and a divisor setting D, the baud tick repeats every (N+1)(D+1) input cycles. Across the ranges of the two settings, common input clocks can reach the usual rates from 50 up to 38,400 baud.

The CPU may rewrite either setting at any time. A stage takes a new value only when its count wraps, so a period already in progress always runs to its end. Reset clears both counts and latches the settings present at that moment. No tick appears until the first full period has elapsed.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both `sys_en` and `baud_tick` are low.
- R2: With prescale setting N held constant, `sys_en` is a one-cycle pulse that is high once every N+1 cycles. With N = 0 it is high in every cycle.
- R3: With divisor setting D held constant, `baud_tick` goes high once for every D+1 `sys_en` pulses. Each tick falls in the cycle just after the `sys_en` pulse that completes the count.
- R4: A prescale value written during a period does not change that period. It sets the length of the next one, counted from the pulse that ends the current period.
- R5: A divisor value written during a baud period does not change that period. It takes effect from the baud tick that ends the current period.
- R6: Count clock edges from the first edge at which `rst` is low. `sys_en` is first high after edge N+1. `baud_tick` is first high after edge (N+1)(D+1)+1. N and D are the values held during reset.
- R7: The largest settings, N = 15 and D = 4095, give a first baud tick after edge 65,537, and nothing earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | PRE_W (4) | Prescale setting N; divides by N+1 |
| div_sel | input | DIV_W (12) | Divisor setting D; one tick per D+1 system enables |
| sys_en | output | 1 | One-cycle system clock enable |
| baud_tick | output | 1 | One-cycle bit-rate tick |

## Verification
The assertions check several rules on every cycle:
- Each count stays within its active limit.
- An active limit changes only on a wrap.
- A tick follows an input enable.
- A baud tick never appears without a system enable in the cycle before.

These rules cannot show that the periods have the right length, or that a rewritten setting waits for the next reload. The bench covers those properties. Its reference model is built on event times. It predicts each pulse from the settings held at the previous wrap, under directed mid-period rewrites, both extreme settings and randomly changing settings.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
    localparam int PRE_W_DEF = 4;
    localparam int DIV_W_DEF = 12;

    // Input-clock cycles in one baud period for given settings
    function automatic int unsigned period_cycles(input int unsigned n, input int unsigned d);
        return (n + 1) * (d + 1);
    endfunction
endpackage

// File: rtl/bdg_limit_reg.sv
module bdg_limit_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] lim_o
);
    typedef struct packed {
        logic [W-1:0] lim;
    } lim_st_t;

    lim_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.lim = set_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{lim: set_i};
        end else begin
            st_q <= st_d;
        end
    end

    assign lim_o = st_q.lim;

    // R4 / R5: active limit only moves on a reload
    p_limit_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> $stable(lim_o));
endmodule

// File: rtl/bdg_count_stage.sv
module bdg_count_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] lim_i,
    output logic         wrap_o,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_lim;

    assign at_lim = (st_q.cnt == lim_i);
    assign wrap_o = en_i && at_lim;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (en_i) begin
            if (at_lim) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R2: count never passes the active limit
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= lim_i);

    // R3: a tick is always caused by an input enable one cycle earlier
    p_tick_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(en_i));

    // R1: first cycle out of reset is quiet
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tick_o);
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import bdg_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF,
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] presc_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             sys_en,
    output logic             baud_tick
);
    logic [PRE_W-1:0] pre_lim;
    logic [DIV_W-1:0] div_lim;
    logic             pre_wrap;
    logic             div_wrap;

    // Stage 1: prescaler, counts every input clock
    bdg_limit_reg #(.W(PRE_W)) u_pre_lim (
        .clk   (clk),
        .rst   (rst),
        .load  (pre_wrap),
        .set_i (presc_sel),
        .lim_o (pre_lim)
    );

    bdg_count_stage #(.W(PRE_W)) u_pre_cnt (
        .clk    (clk),
        .rst    (rst),
        .en_i   (1'b1),
        .lim_i  (pre_lim),
        .wrap_o (pre_wrap),
        .tick_o (sys_en)
    );

    // Stage 2: divider, counts system enables
    bdg_limit_reg #(.W(DIV_W)) u_div_lim (
        .clk   (clk),
        .rst   (rst),
        .load  (div_wrap),
        .set_i (div_sel),
        .lim_o (div_lim)
    );

    bdg_count_stage #(.W(DIV_W)) u_div_cnt (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sys_en),
        .lim_i  (div_lim),
        .wrap_o (div_wrap),
        .tick_o (baud_tick)
    );

    // R3: a baud tick is always preceded by a system enable
    p_baud_after_sys_r3: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(sys_en));
endmodule

// File: tb/tb_baud_rate_gen.sv
`timescale 1ns/1ps
module tb_baud_rate_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  presc_sel = '0;
    logic [11:0] div_sel = '0;
    logic        sys_en;
    logic        baud_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state (event times)
    int t;
    int next_sys_t;
    int dcnt;
    int dlim;
    bit pend_sys;
    bit exp_baud;
    string sys_req  = "R2";
    string baud_req = "R3";

    always #2.5 clk = ~clk;

    baud_rate_gen dut (
        .clk       (clk),
        .rst       (rst),
        .presc_sel (presc_sel),
        .div_sel   (div_sel),
        .sys_en    (sys_en),
        .baud_tick (baud_tick)
    );

    function automatic int first_baud_edge(input int n, input int d);
        return (n + 1) * (d + 1) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
        end
    endtask

    task automatic start(input int n, input int d);
        @(negedge clk);
        rst = 1'b1;
        presc_sel = 4'(n);
        div_sel = 12'(d);
        repeat (3) @(negedge clk);
        check(sys_en == 1'b0, "R1", int'(sys_en), 0);
        check(baud_tick == 1'b0, "R1", int'(baud_tick), 0);
        rst = 1'b0;
        t = 0;
        next_sys_t = n + 1;
        dcnt = 0;
        dlim = d;
        pend_sys = 0;
        exp_baud = 0;
    endtask

    // One cycle: account the divider for the coming edge, then sample
    task automatic step();
        bit exp_sys;
        exp_baud = 0;
        if (pend_sys) begin
            dcnt++;
            if (dcnt == dlim + 1) begin
                exp_baud = 1;
                dcnt = 0;
                dlim = int'(div_sel);
            end
        end
        @(negedge clk);
        t++;
        exp_sys = (t == next_sys_t);
        check(sys_en == exp_sys, sys_req, int'(sys_en), int'(exp_sys));
        check(baud_tick == exp_baud, baud_req, int'(baud_tick), int'(exp_baud));
        if (t == 1) begin
            check(1'b1 && !(sys_en && !exp_sys), "R1", int'(sys_en), int'(exp_sys));
        end
        if (exp_sys) next_sys_t = t + int'(presc_sel) + 1;
        pend_sys = exp_sys;
    endtask

    task automatic first_baud_check(input int n, input int d, input string req);
        int seen;
        seen = -1;
        start(n, d);
        for (int i = 0; i < first_baud_edge(n, d) + 2; i++) begin
            step();
            if (baud_tick && seen < 0) seen = t;
        end
        check(seen == first_baud_edge(n, d), req, seen, first_baud_edge(n, d));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int sys_seen [$];
        int unsigned r;
        r = $urandom(32'd12345);

        // R1, R2: pass-through prescale, baud every cycle with D=0
        sys_req = "R2"; baud_req = "R3";
        start(0, 0);
        for (int i = 0; i < 12; i++) step();

        // R6: first ticks for a mid setting, then steady periods
        sys_req = "R6"; baud_req = "R6";
        first_baud_check(3, 5, "R6");
        sys_req = "R2"; baud_req = "R3";
        for (int i = 0; i < 150; i++) step();

        // R4: prescale rewritten mid-period, old period must complete
        sys_req = "R4"; baud_req = "R4";
        start(7, 1);
        sys_seen.delete();
        for (int i = 0; i < 12; i++) begin
            step();
            if (sys_en) sys_seen.push_back(t);
            if (t == 3) presc_sel = 4'd1;
        end
        check(sys_seen.size() >= 2 && sys_seen[0] == 8, "R4", sys_seen.size() > 0 ? sys_seen[0] : -1, 8);
        check(sys_seen.size() >= 2 && sys_seen[1] == 10, "R4", sys_seen.size() > 1 ? sys_seen[1] : -1, 10);

        // R5: divisor rewritten mid baud period
        sys_req = "R2"; baud_req = "R5";
        start(1, 9);
        begin
            int b0;
            int b1;
            b0 = -1; b1 = -1;
            for (int i = 0; i < 40; i++) begin
                step();
                if (t == 5) div_sel = 12'd2;
                if (baud_tick) begin
                    if (b0 < 0) b0 = t; else if (b1 < 0) b1 = t;
                end
            end
            // first period with D=9: edge 21; next with D=2: 6 cycles later
            check(b0 == 21, "R5", b0, 21);
            check(b1 == 27, "R5", b1, 27);
        end

        // Random settings changing at random times
        sys_req = "R4"; baud_req = "R5";
        start(2, 3);
        for (int i = 0; i < 4000; i++) begin
            step();
            if (($urandom % 40) == 0) presc_sel = 4'($urandom % 8);
            if (($urandom % 60) == 0) div_sel = 12'($urandom % 16);
        end

        // R7: extreme settings
        sys_req = "R7"; baud_req = "R7";
        first_baud_check(15, 4095, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule